// File: doc/BRIEF.md
# Calendar Real-Time Clock Register File

This block keeps wall-clock time and a calendar in a small byte-addressed register file. The calendar holds seconds, minutes, hours, day of week, day of month, month and a two-digit year. A one-cycle strobe on `sec_tick` advances it by one second, with all carries through the calendar, including month lengths and leap years. A host reads and writes through a simple synchronous port. Time bytes and four control/status bytes share one address space. The host read data is registered and appears one cycle after the read request.

A mode bit in control register B chooses how every time field appears to the host. When it is 0, fields appear as packed BCD. When it is 1, fields appear as plain binary. The core keeps the calendar in binary internally and converts at the host boundary. A hold bit in register B freezes the calendar. A periodic-interrupt enable produces a one-cycle interrupt pulse at a fixed rate of `PIE_HZ`, derived from the system clock frequency `CLK_HZ`.

Control register A carries a busy flag in bit 7. Every host read of register A returns that flag inverted and leaves it inverted. Host writes never change the flag. Registers C and D exist only as read-as-zero locations.

Top module: `rtc_calendar`

## Requirements
- R1: The address map is seconds 0x00, minutes 0x02, hours 0x04, day of week 0x06, day of month 0x07, month 0x08, year 0x09, register A 0x0A, register B 0x0B, register C 0x0C and register D 0x0D. Any other address reads 0x00, and writes to it change nothing.
- R2: After reset, the time is 00:00:00 with day of week 1, day of month 1, month 1 and year 0. Register A holds busy flag bit7=0, time-base field bits[6:4]=3'b010 and rate field bits[3:0]=4'b0110. Register B holds hold bit7=0, interrupt enable bit6=1, mode bit2 set to the `BIN_MODE_RST` parameter, 24-hour bit1=1, and all other bits 0. The read data output holds 0x00.
- R3: When register B bit2 is 0, time bytes are written and read as packed BCD (tens digit in bits[7:4], units in bits[3:0]). When bit2 is 1, they are written and read as plain binary. Changing the bit re-presents the stored time in the new form.
- R4: A `sec_tick` pulse advances the seconds, wrapping 59 to 0. The wrap carries into minutes (59 to 0), and the minute wrap carries into hours (23 to 0).
- R5: When the hours wrap, the day of week advances from 1 to 7 and then wraps from 7 back to 1.
- R6: When the hours wrap, the day of month advances. It wraps to 1 after day 30 for months 4, 6, 9 and 11, and after day 31 for the other months. For month 2 it wraps after day 29 when the year is divisible by 4, and after day 28 otherwise. A month wrap takes 12 to 1 and carries into the year, which wraps from 99 to 0.
- R7: While register B bit7 (hold) is 1, `sec_tick` leaves all time fields unchanged.
- R8: A host write to a time byte replaces the live field at once. If a `sec_tick` arrives in the same cycle, the write takes effect and the tick is dropped.
- R9: A host write to register A updates bits[6:0] but leaves bit 7 (the busy flag) unchanged.
- R10: Each host read of register A returns the busy flag inverted in bit 7 and stores the inverted value.
- R11: Registers C and D always read 0x00, even after a write to them.
- R12: While register B bit6 is 1, `irq_o` gives a one-cycle pulse every `CLK_HZ/PIE_HZ` cycles. In the cycle after the bit is cleared, `irq_o` is 0, and it stays 0 while the bit is 0.
- R13: `host_rdata` updates in the clock cycle after a cycle with `host_re` high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle strobe, once per second |
| host_we | input | 1 | Host write request |
| host_re | input | 1 | Host read request |
| host_addr | input | ADDR_W | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| irq_o | output | 1 | Periodic interrupt pulse |

## Verification
The calendar is tried with three kinds of input:
- Uniformly random valid dates and times, which separate normal single-step increments from carry handling.
- Dates biased to the last second of a day and the last day of a month, which exercise every carry stage at once.
- Directed end-of-February cases in leap and non-leap years, and the end of year 99, which tell month-length and year-wrap errors apart.

Random switching of the mode bit between loads shows whether BCD and binary conversion is applied on both the write path and the read path. Control-register patterns check the busy flag separately for reads and for writes. A tick that collides with a write checks the write priority. The interrupt pulse spacing is measured with the enable set and checked for silence with the enable cleared.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int BYTE_W  = 8;
    localparam int FIELD_N = 7;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        F_SEC  = 3'd0,
        F_MIN  = 3'd1,
        F_HOUR = 3'd2,
        F_WDAY = 3'd3,
        F_MDAY = 3'd4,
        F_MON  = 3'd5,
        F_YEAR = 3'd6
    } field_e;

    // Seconds in the least significant byte so the packed view indexes by field_e.
    typedef struct packed {
        byte_t year;
        byte_t mon;
        byte_t mday;
        byte_t wday;
        byte_t hour;
        byte_t min;
        byte_t sec;
    } cal_t;

    typedef logic [FIELD_N-1:0][BYTE_W-1:0] cal_vec_t;

    typedef struct packed {
        logic       busy_flag;
        logic [2:0] tb_sel;
        logic [3:0] rate_sel;
    } ctl_a_t;

    typedef struct packed {
        logic upd_hold;
        logic per_irq_en;
        logic alarm_en;
        logic upd_irq_en;
        logic sqw_en;
        logic bin_mode;
        logic fmt_24h;
        logic dst_en;
    } ctl_b_t;

    localparam logic [2:0] TB_32K   = 3'b010;
    localparam logic [3:0] RATE_1K  = 4'b0110;

    localparam byte_t ADR_SEC  = 8'h00;
    localparam byte_t ADR_MIN  = 8'h02;
    localparam byte_t ADR_HOUR = 8'h04;
    localparam byte_t ADR_WDAY = 8'h06;
    localparam byte_t ADR_MDAY = 8'h07;
    localparam byte_t ADR_MON  = 8'h08;
    localparam byte_t ADR_YEAR = 8'h09;
    localparam byte_t ADR_CA   = 8'h0A;
    localparam byte_t ADR_CB   = 8'h0B;
    localparam byte_t ADR_CC   = 8'h0C;
    localparam byte_t ADR_CD   = 8'h0D;

    localparam cal_t CAL_RESET = '{
        year: 8'd0, mon: 8'd1, mday: 8'd1, wday: 8'd1,
        hour: 8'd0, min: 8'd0, sec: 8'd0
    };

    function automatic byte_t bin2bcd(byte_t v);
        byte_t tens;
        byte_t units;
        tens  = v / 8'd10;
        units = v % 8'd10;
        return byte_t'(tens << 4) + units;
    endfunction

    function automatic byte_t bcd2bin(byte_t v);
        return byte_t'(v[7:4]) * 8'd10 + byte_t'(v[3:0]);
    endfunction

    function automatic byte_t month_len(byte_t mon, logic [1:0] yr_lo);
        case (mon)
            8'd2:                    return (yr_lo == 2'b00) ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11: return 8'd30;
            default:                 return 8'd31;
        endcase
    endfunction

    // One-second advance with the full carry chain; out-of-range values wrap.
    function automatic cal_t cal_step(cal_t c);
        cal_t n;
        n = c;
        if (c.sec >= 8'd59) begin
            n.sec = 8'd0;
            if (c.min >= 8'd59) begin
                n.min = 8'd0;
                if (c.hour >= 8'd23) begin
                    n.hour = 8'd0;
                    n.wday = (c.wday >= 8'd7) ? 8'd1 : c.wday + 8'd1;
                    if (c.mday >= month_len(c.mon, c.year[1:0])) begin
                        n.mday = 8'd1;
                        if (c.mon >= 8'd12) begin
                            n.mon  = 8'd1;
                            n.year = (c.year >= 8'd99) ? 8'd0 : c.year + 8'd1;
                        end else begin
                            n.mon = c.mon + 8'd1;
                        end
                    end else begin
                        n.mday = c.mday + 8'd1;
                    end
                end else begin
                    n.hour = c.hour + 8'd1;
                end
            end else begin
                n.min = c.min + 8'd1;
            end
        end else begin
            n.sec = c.sec + 8'd1;
        end
        return n;
    endfunction

endpackage

// File: rtl/rtc_cal_counter.sv
module rtc_cal_counter
    import rtc_cal_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   adv_en,
    input  logic   wr_en,
    input  field_e wr_field,
    input  byte_t  wr_val,
    output cal_t   cal_q
);

    cal_vec_t wr_next;

    always_comb begin
        wr_next           = cal_vec_t'(cal_q);
        wr_next[wr_field] = wr_val;
    end

    // Host write has priority over the second advance (R8).
    always_ff @(posedge clk) begin
        if (rst) begin
            cal_q <= CAL_RESET;
        end else if (wr_en) begin
            cal_q <= cal_t'(wr_next);
        end else if (adv_en) begin
            cal_q <= cal_step(cal_q);
        end
    end

endmodule

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
    import rtc_cal_pkg::*;
#(
    parameter bit BIN_MODE_RST = 1'b0
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_a,
    input  logic   rd_a,
    input  logic   wr_b,
    input  byte_t  wdata,
    output ctl_a_t reg_a,
    output ctl_b_t reg_b
);

    localparam ctl_a_t A_RESET = '{busy_flag: 1'b0, tb_sel: TB_32K, rate_sel: RATE_1K};
    localparam ctl_b_t B_RESET = '{
        upd_hold: 1'b0, per_irq_en: 1'b1, alarm_en: 1'b0, upd_irq_en: 1'b0,
        sqw_en: 1'b0, bin_mode: BIN_MODE_RST, fmt_24h: 1'b1, dst_en: 1'b0
    };

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_a <= A_RESET;
            reg_b <= B_RESET;
        end else begin
            if (wr_a) begin
                reg_a.tb_sel   <= wdata[6:4];
                reg_a.rate_sel <= wdata[3:0];
            end
            if (rd_a) begin
                reg_a.busy_flag <= ~reg_a.busy_flag;
            end
            if (wr_b) begin
                reg_b <= ctl_b_t'(wdata);
            end
        end
    end

endmodule

// File: rtl/rtc_pie_gen.sv
module rtc_pie_gen #(
    parameter int DIV = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic irq
);

    localparam int            CW   = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
            irq <= 1'b0;
        end else begin
            irq <= (cnt == LAST);
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_cal_pkg::*;
#(
    parameter int CLK_HZ       = 1048576,
    parameter int PIE_HZ       = 1024,
    parameter bit BIN_MODE_RST = 1'b0,
    parameter int ADDR_W       = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sec_tick,
    input  logic              host_we,
    input  logic              host_re,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic              irq_o
);

    localparam int PIE_DIV = CLK_HZ / PIE_HZ;

    ctl_a_t   reg_a;
    ctl_b_t   reg_b;
    cal_t     cal_q;
    cal_vec_t cal_vec;
    cal_vec_t cal_enc;
    field_e   fld_sel;
    logic     fld_hit;
    logic     hit_a;
    logic     hit_b;
    byte_t    wr_bin;
    byte_t    rd_mux;
    byte_t    rdata_q;

    // Address decode for the time bytes.
    always_comb begin
        fld_hit = 1'b1;
        fld_sel = F_SEC;
        case (host_addr)
            ADDR_W'(ADR_SEC):  fld_sel = F_SEC;
            ADDR_W'(ADR_MIN):  fld_sel = F_MIN;
            ADDR_W'(ADR_HOUR): fld_sel = F_HOUR;
            ADDR_W'(ADR_WDAY): fld_sel = F_WDAY;
            ADDR_W'(ADR_MDAY): fld_sel = F_MDAY;
            ADDR_W'(ADR_MON):  fld_sel = F_MON;
            ADDR_W'(ADR_YEAR): fld_sel = F_YEAR;
            default:           fld_hit = 1'b0;
        endcase
    end

    assign hit_a  = (host_addr == ADDR_W'(ADR_CA));
    assign hit_b  = (host_addr == ADDR_W'(ADR_CB));
    assign wr_bin = reg_b.bin_mode ? host_wdata : bcd2bin(host_wdata);

    rtc_cal_counter u_cal (
        .clk      (clk),
        .rst      (rst),
        .adv_en   (sec_tick && !reg_b.upd_hold),
        .wr_en    (host_we && fld_hit),
        .wr_field (fld_sel),
        .wr_val   (wr_bin),
        .cal_q    (cal_q)
    );

    rtc_ctrl_regs #(
        .BIN_MODE_RST (BIN_MODE_RST)
    ) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .wr_a  (host_we && hit_a),
        .rd_a  (host_re && hit_a),
        .wr_b  (host_we && hit_b),
        .wdata (host_wdata),
        .reg_a (reg_a),
        .reg_b (reg_b)
    );

    rtc_pie_gen #(
        .DIV (PIE_DIV)
    ) u_pie (
        .clk (clk),
        .rst (rst),
        .en  (reg_b.per_irq_en),
        .irq (irq_o)
    );

    // Host-side presentation of every field in the selected number form.
    assign cal_vec = cal_vec_t'(cal_q);
    for (genvar g = 0; g < FIELD_N; g++) begin : g_enc
        assign cal_enc[g] = reg_b.bin_mode ? cal_vec[g] : bin2bcd(cal_vec[g]);
    end

    always_comb begin
        rd_mux = '0;
        if (fld_hit) begin
            rd_mux = cal_enc[fld_sel];
        end else if (hit_a) begin
            rd_mux = {~reg_a.busy_flag, reg_a.tb_sel, reg_a.rate_sel};
        end else if (hit_b) begin
            rd_mux = byte_t'(reg_b);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (host_re) begin
            rdata_q <= rd_mux;
        end
    end

    assign host_rdata = rdata_q;

endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
    import rtc_cal_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              sec_tick,
    input logic              host_we,
    input logic              host_re,
    input logic [ADDR_W-1:0] host_addr,
    input logic [7:0]        host_rdata,
    input logic              irq_o,
    input logic              busy,
    input logic              per_en,
    input logic              upd_hold,
    input cal_t              cal
);

    logic at_a;
    logic at_cd;
    logic at_time;

    assign at_a  = (host_addr == ADDR_W'(ADR_CA));
    assign at_cd = (host_addr == ADDR_W'(ADR_CC)) || (host_addr == ADDR_W'(ADR_CD));
    assign at_time = (host_addr == ADDR_W'(ADR_SEC))  || (host_addr == ADDR_W'(ADR_MIN))  ||
                     (host_addr == ADDR_W'(ADR_HOUR)) || (host_addr == ADDR_W'(ADR_WDAY)) ||
                     (host_addr == ADDR_W'(ADR_MDAY)) || (host_addr == ADDR_W'(ADR_MON))  ||
                     (host_addr == ADDR_W'(ADR_YEAR));

    // R10
    busy_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (host_re && at_a) |=> (busy != $past(busy)));

    // R9
    busy_write_chk: assert property (@(posedge clk) disable iff (rst)
        (host_we && at_a && !host_re) |=> $stable(busy));

    // R11
    cd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (host_re && at_cd) |=> (host_rdata == 8'h00));

    // R7
    hold_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_hold && sec_tick && !(host_we && at_time)) |=> $stable(cal));

    // R4
    sec_moves_chk: assert property (@(posedge clk) disable iff (rst)
        (!upd_hold && sec_tick && !(host_we && at_time)) |=> (cal.sec != $past(cal.sec)));

    // R12
    irq_off_chk: assert property (@(posedge clk) disable iff (rst)
        !per_en |=> !irq_o);

    // R12
    irq_width_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |=> !irq_o);

    // R13
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !host_re |=> $stable(host_rdata));

endmodule

bind rtc_calendar rtc_calendar_chk #(
    .ADDR_W (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sec_tick   (sec_tick),
    .host_we    (host_we),
    .host_re    (host_re),
    .host_addr  (host_addr),
    .host_rdata (host_rdata),
    .irq_o      (irq_o),
    .busy       (reg_a.busy_flag),
    .per_en     (reg_b.per_irq_en),
    .upd_hold   (reg_b.upd_hold),
    .cal        (cal_q)
);

// File: tb/rtc_calendar_tb_top.sv
module rtc_calendar_tb_top;

    localparam int CLK_HZ = 20480;
    localparam int PIE_HZ = 1024;
    localparam int DIV    = CLK_HZ / PIE_HZ;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sec_tick = 1'b0;
    logic       host_we = 1'b0;
    logic       host_re = 1'b0;
    logic [7:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       irq_o;

    int n_chk  = 0;
    int n_fail = 0;

    int e [7];           // expected binary fields: sec,min,hour,wday,mday,mon,year
    bit m_bin  = 1'b0;
    bit m_busy = 1'b0;
    bit m_hold = 1'b0;
    int m_alow = 8'h26;

    always #2 clk = ~clk;

    rtc_calendar #(
        .CLK_HZ       (CLK_HZ),
        .PIE_HZ       (PIE_HZ),
        .BIN_MODE_RST (1'b0),
        .ADDR_W       (8)
    ) dut_i (
        .clk        (clk),
        .rst        (rst),
        .sec_tick   (sec_tick),
        .host_we    (host_we),
        .host_re    (host_re),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .irq_o      (irq_o)
    );

    function automatic int to_bcd(int v);
        return ((v / 10) << 4) + (v % 10);
    endfunction

    function automatic int enc(int v);
        return m_bin ? v : to_bcd(v);
    endfunction

    function automatic int fld_addr(int i);
        case (i)
            0: return 8'h00;
            1: return 8'h02;
            2: return 8'h04;
            3: return 8'h06;
            4: return 8'h07;
            5: return 8'h08;
            default: return 8'h09;
        endcase
    endfunction

    function automatic int mdays(int mo, int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic report();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s got=0x%0h exp=0x%0h", req, got, exp);
        end
    endtask

    task automatic host_wr(input int addr, input int data);
        @(negedge clk);
        host_we    = 1'b1;
        host_addr  = addr[7:0];
        host_wdata = data[7:0];
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic host_rd(input int addr, output int data);
        @(negedge clk);
        host_re   = 1'b1;
        host_addr = addr[7:0];
        @(negedge clk);
        host_re = 1'b0;
        data    = int'(host_rdata);
    endtask

    task automatic m_tick();
        if (m_hold) return;
        if (e[0] >= 59) begin
            e[0] = 0;
            if (e[1] >= 59) begin
                e[1] = 0;
                if (e[2] >= 23) begin
                    e[2] = 0;
                    e[3] = (e[3] >= 7) ? 1 : e[3] + 1;
                    if (e[4] >= mdays(e[5], e[6])) begin
                        e[4] = 1;
                        if (e[5] >= 12) begin
                            e[5] = 1;
                            e[6] = (e[6] >= 99) ? 0 : e[6] + 1;
                        end else e[5]++;
                    end else e[4]++;
                end else e[2]++;
            end else e[1]++;
        end else e[0]++;
    endtask

    task automatic tick();
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        m_tick();
    endtask

    task automatic set_b(input int v);
        host_wr(8'h0B, v);
        m_bin  = v[2];
        m_hold = v[7];
    endtask

    task automatic load(input int s, input int mi, input int h, input int wd,
                        input int md, input int mo, input int y);
        e[0] = s; e[1] = mi; e[2] = h; e[3] = wd; e[4] = md; e[5] = mo; e[6] = y;
        for (int i = 0; i < 7; i++) host_wr(fld_addr(i), enc(e[i]));
    endtask

    task automatic check_all(input string req);
        int v;
        for (int i = 0; i < 7; i++) begin
            host_rd(fld_addr(i), v);
            chk(req, v, enc(e[i]));
        end
    endtask

    task automatic read_a(input string req);
        int v;
        host_rd(8'h0A, v);
        chk(req, v, {24'd0, ~m_busy, m_alow[6:0]});
        m_busy = ~m_busy;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        int v;
        int v2;
        int n;
        int seed;
        seed = $urandom(32'd7351);
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R2: reset state of read data, time and control bytes
        @(negedge clk);
        chk("R2 rdata", int'(host_rdata), 0);
        e[0] = 0; e[1] = 0; e[2] = 0; e[3] = 1; e[4] = 1; e[5] = 1; e[6] = 0;
        check_all("R2 time");
        host_rd(8'h0B, v);
        chk("R2 regB", v, 8'h42);
        // R10: busy flag toggles on each read of A
        read_a("R10 first read");
        read_a("R10 second read");
        // R9: write to A keeps the busy flag
        host_wr(8'h0A, 8'hFF);
        m_alow = 8'h7F;
        read_a("R9 write keeps busy");
        host_wr(8'h0A, 8'h26);
        m_alow = 8'h26;
        read_a("R9 lower bits");

        // R11: C and D read zero
        host_wr(8'h0C, 8'h5A);
        host_rd(8'h0C, v);
        chk("R11 regC", v, 0);
        host_rd(8'h0D, v);
        chk("R11 regD", v, 0);

        // R1: unmapped addresses
        load(10, 20, 5, 3, 12, 6, 21);
        host_wr(8'h01, 8'h55);
        host_rd(8'h01, v);
        chk("R1 unmapped read", v, 0);
        host_rd(8'h0E, v);
        chk("R1 unmapped 0E", v, 0);
        check_all("R1 time untouched");

        // R13: read data holds without a read request
        host_rd(8'h00, v);
        repeat (3) @(negedge clk);
        tick();
        chk("R13 hold", int'(host_rdata), v);

        // R4 R5 R6: end of year 99
        load(59, 59, 23, 7, 31, 12, 99);
        tick();
        check_all("R6 year wrap");
        chk("R5 wday wrap", e[3], 1);
        // R6: February, leap and non-leap
        load(59, 59, 23, 2, 28, 2, 24);
        tick();
        check_all("R6 leap feb28");
        tick();
        check_all("R4 plain second");
        load(59, 59, 23, 2, 29, 2, 24);
        tick();
        check_all("R6 leap feb29");
        load(59, 59, 23, 2, 28, 2, 23);
        tick();
        check_all("R6 nonleap feb28");
        load(59, 59, 23, 4, 30, 4, 50);
        tick();
        check_all("R6 april");
        load(59, 58, 22, 4, 30, 4, 50);
        tick();
        check_all("R4 minute carry");

        // R3: BCD write, binary re-presentation
        host_wr(8'h00, 8'h45);
        e[0] = 45;
        host_rd(8'h00, v);
        chk("R3 bcd read", v, 8'h45);
        set_b(8'h46);
        host_rd(8'h00, v);
        chk("R3 bin view", v, 45);
        host_wr(8'h02, 37);
        e[1] = 37;
        set_b(8'h42);
        host_rd(8'h02, v);
        chk("R3 bcd view", v, 8'h37);

        // R7: hold bit suppresses ticks
        set_b(8'hC2);
        tick();
        tick();
        check_all("R7 hold");
        set_b(8'h42);
        tick();
        check_all("R7 release");

        // R8: write and tick in the same cycle
        @(negedge clk);
        host_we    = 1'b1;
        host_addr  = 8'h00;
        host_wdata = 8'h30;
        sec_tick   = 1'b1;
        @(negedge clk);
        host_we  = 1'b0;
        sec_tick = 1'b0;
        e[0] = 30;
        check_all("R8 write wins");

        // Random loads in both forms, biased toward rollovers
        for (int it = 0; it < 150; it++) begin
            if ($urandom % 4 == 0) set_b(($urandom % 2) ? 8'h46 : 8'h42);
            e[6] = $urandom % 100;
            e[5] = 1 + $urandom % 12;
            e[3] = 1 + $urandom % 7;
            if ($urandom % 3 == 0) begin
                e[0] = 59; e[1] = 59; e[2] = 23;
                e[4] = mdays(e[5], e[6]);
            end else begin
                e[0] = $urandom % 60; e[1] = $urandom % 60; e[2] = $urandom % 24;
                e[4] = 1 + $urandom % mdays(e[5], e[6]);
            end
            load(e[0], e[1], e[2], e[3], e[4], e[5], e[6]);
            n = $urandom % 3;
            for (int k = 0; k < n; k++) tick();
            check_all(m_bin ? "R3 R4 R6 random bin" : "R3 R4 R6 random bcd");
        end

        // R12: periodic pulse spacing, width and disable
        set_b(8'h42);
        n = 0;
        while (irq_o !== 1'b1 && n < 4 * DIV) begin
            @(negedge clk);
            n++;
        end
        chk("R12 pulse seen", int'(irq_o), 1);
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 1) chk("R12 width", int'(irq_o), 0);
        end while (irq_o !== 1'b1 && n < 4 * DIV);
        chk("R12 spacing", n, DIV);
        set_b(8'h02);
        v2 = 0;
        for (int k = 0; k < 5 * DIV; k++) begin
            @(negedge clk);
            if (irq_o) v2++;
        end
        chk("R12 disabled", v2, 0);
        set_b(8'h42);
        v2 = 0;
        for (int k = 0; k < DIV + 2; k++) begin
            @(negedge clk);
            if (irq_o) v2++;
        end
        chk("R12 restart", v2, 1);

        report();
    end

endmodule